// File: doc/BRIEF.md
# Asynchronous Serial Port with Extension-Bit Characters

This block is a full-duplex asynchronous serial port with one transmit line and one receive line. Characters are 7 or 8 data bits, or 9 bits where the ninth is an extension bit. An optional parity bit can be odd, even or forced to zero. One or two stop bits are sent. Both directions run from a common tick at sixteen times the bit rate. The tick comes from a programmable divider or from the bus clock divided by two.

Transmit words arrive on a valid/ready stream and load straight into the shift register, so there is no transmit buffer. `tx_ready` is high only while the transmitter is idle and enabled. It stays low from the accepting edge until the last stop bit has left the line, so a producer simply holds `tx_valid` and its word until the handshake completes. Received characters go into one holding buffer that is presented as a valid/ready stream. `rx_data` stays stable while `rx_valid` is high and `rx_ready` is low. A character that completes while the buffer is still unread is dropped and counted as an overrun.

Parity, framing and overrun errors are kept in a sticky status word that clears when it is read. They also raise one combined error pulse. Separate one-cycle pulses mark the end of a transmitted character and the loading of a received one.

Top module: `async_serial_port`

## Requirements
- R1: After reset `txd` is 1, `rx_valid` is 0 and `stat_flags` is 0. With `tx_en` high, `tx_ready` is 1.
- R2: Bit clock source. With `cfg_clk_sel`=0 the 16x tick fires every `cfg_div`+1 clocks. With `cfg_clk_sel`=1 it fires every 2 clocks. Every bit on either line lasts 16 ticks.
- R3: A transmitted frame is sent in this order: a 0 start bit, then the data bits LSB first, then the parity bit if one is used, then the stop bits. `cfg_len` selects 7 data bits (0), 8 (1) or 9 (2). `cfg_stop2`=1 sends two stop bits of 1, and `cfg_stop2`=0 sends one.
- R4: Parity is set by `cfg_par`. 0 sends no parity bit. 1 sends a parity bit of 0. 2 makes the count of ones over data and parity odd. 3 makes that count even. No parity bit is sent or expected with 9-bit characters.
- R5: A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` then stays low until the frame has finished. While `tx_en` is low no word is accepted and `txd` stays 1.
- R6: `tx_end` is a single-cycle pulse that follows the end of the last stop bit. Exactly one pulse is given per frame.
- R7: A start bit is accepted only after 8 consecutive low tick samples. A shorter low pulse is ignored. After a frame, no new start is looked for until the line has been seen high.
- R8: A received character is loaded into the buffer. It appears on `rx_data`, zero-extended above the character length, with `rx_valid` high. It stays there until it is taken with `rx_ready`. `rx_end` pulses once for each load.
- R9: While `rx_en` is low the receiver is held idle. Nothing is loaded and `rx_end` does not pulse.
- R10: When an odd or even parity bit does not match, `stat_flags[0]` is set. The received parity bit is not checked in forced-zero mode.
- R11: A low first stop bit sets `stat_flags[1]`. The character is still loaded.
- R12: A character that completes while `rx_valid` is high and `rx_ready` is low sets `stat_flags[2]`. That character is discarded and the buffer keeps its old value.
- R13: `err_irq` pulses once for each received character that has any error. A one-cycle `stat_rd` clears `stat_flags`, but an error arriving in that same cycle still sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_clk_sel | input | 1 | 0: programmable divider, 1: bus clock / 2 |
| cfg_div | input | DIV_W | Divider value; tick period is cfg_div+1 clocks |
| cfg_len | input | 2 | Character length: 0=7, 1=8, 2=9 bits |
| cfg_par | input | 2 | 0 none, 1 zero, 2 odd, 3 even |
| cfg_stop2 | input | 1 | Two transmit stop bits when 1 |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmitter idle and able to accept |
| tx_data | input | 9 | Transmit word, LSB sent first |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_valid | output | 1 | Receive buffer holds a character |
| rx_ready | input | 1 | Consumer takes the buffered character |
| rx_data | output | 9 | Buffered character |
| tx_end | output | 1 | Transmit-end pulse |
| rx_end | output | 1 | Receive-end pulse |
| err_irq | output | 1 | Combined receive-error pulse |
| stat_rd | input | 1 | Status read strobe, clears flags |
| stat_flags | output | 3 | {overrun, framing, parity} |

## Verification
Transmit frames are built with each character length and each parity mode, and with one or two stop bits. The line is checked at every bit centre, which separates bit-order, parity-polarity and stop-count faults. The same frame is also sent from the divided bus clock, where a wrong period drifts the later bits away from the checked centres. On the receive side, frames are sent with correct parity, wrong parity, a forced-one bit in zero-parity mode and a low stop bit, which tells the three error kinds apart and shows that zero parity is not checked. Further patterns are a second character into an unread buffer, a short low glitch, and a frame sent while reception is disabled; these show that a character is dropped, that a glitch is not taken as a start, and that nothing loads while reception is off.

// File: rtl/aser_pkg.sv
package aser_pkg;
  localparam int OVS      = 16;
  localparam int SUB_W    = $clog2(OVS);
  localparam int MAX_DATA = 9;
  localparam int FRAME_MAX = 1 + MAX_DATA + 1 + 2;

  typedef enum logic [1:0] {LEN_7 = 2'd0, LEN_8 = 2'd1, LEN_9 = 2'd2, LEN_RSV = 2'd3} char_len_e;
  typedef enum logic [1:0] {PAR_NONE = 2'd0, PAR_ZERO = 2'd1, PAR_ODD = 2'd2, PAR_EVEN = 2'd3} par_mode_e;

  function automatic int data_bits(char_len_e l);
    case (l)
      LEN_7:   return 7;
      LEN_9:   return 9;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/aser_tick_gen.sv
module aser_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  assign limit = sel ? DIV_W'(1) : div;
  assign tick  = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/aser_tx_engine.sv
module aser_tx_engine
  import aser_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [1:0]          len,
  input  logic [1:0]          par,
  input  logic                stop2,
  input  logic                en,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [MAX_DATA-1:0] in_data,
  output logic                txd,
  output logic                done
);
  localparam int FW = FRAME_MAX;
  localparam int CW = $clog2(FW + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  char_len_e cl;
  par_mode_e pm;
  int        nd;
  logic      use_par;
  logic      acc;
  logic      pbit;
  logic [FW-1:0] frm;
  logic [CW-1:0] nbits;

  logic [FW-1:0]    sh;
  logic [CW-1:0]    left;
  logic [SUB_W-1:0] sub;
  logic             busy;
  logic             load;

  assign cl      = char_len_e'(len);
  assign pm      = par_mode_e'(par);
  assign nd      = data_bits(cl);
  assign use_par = (pm != PAR_NONE) && (cl != LEN_9);

  always_comb begin
    frm    = '1;
    frm[0] = 1'b0;
    acc    = 1'b0;
    for (int j = 0; j < MAX_DATA; j++) begin
      if (j < nd) begin
        frm[1+j] = in_data[j];
        acc      = acc ^ in_data[j];
      end
    end
    case (pm)
      PAR_ODD:  pbit = ~acc;
      PAR_EVEN: pbit = acc;
      default:  pbit = 1'b0;
    endcase
    if (use_par) frm[1+nd] = pbit;
    nbits = CW'(2 + nd + (use_par ? 1 : 0) + (stop2 ? 1 : 0));
  end

  assign in_ready = !busy && en;
  assign load     = in_valid && in_ready;
  assign txd      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      sub  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sh   <= frm;
        left <= nbits;
        sub  <= '0;
        busy <= 1'b1;
      end else if (busy && tick) begin
        if (sub == SUB_LAST) begin
          sub <= '0;
          if (left == CW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            sh   <= {1'b1, sh[FW-1:1]};
            left <= left - 1'b1;
          end
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aser_rx_engine.sv
module aser_rx_engine
  import aser_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                en,
  input  logic [1:0]          len,
  input  logic [1:0]          par,
  input  logic                rxd,
  output logic                done,
  output logic [MAX_DATA-1:0] data,
  output logic                perr,
  output logic                ferr
);
  localparam int BW = $clog2(MAX_DATA + 2);
  localparam logic [SUB_W-1:0] SUB_LAST  = SUB_W'(OVS - 1);
  localparam logic [SUB_W-1:0] START_MID = SUB_W'(OVS / 2 - 1);

  typedef enum logic [1:0] {ST_WAIT_HI, ST_IDLE, ST_RUN} rx_st_e;

  char_len_e cl;
  par_mode_e pm;
  int        nd;
  int        last;
  logic      has_par;
  logic      chk_par;
  logic      exp_par;

  rx_st_e           st;
  logic             s1, s2;
  logic [SUB_W-1:0] cnt;
  logic [BW-1:0]    bi;
  logic             acc;
  logic             pb;

  assign cl      = char_len_e'(len);
  assign pm      = par_mode_e'(par);
  assign nd      = data_bits(cl);
  assign has_par = (pm != PAR_NONE) && (cl != LEN_9);
  assign chk_par = ((pm == PAR_ODD) || (pm == PAR_EVEN)) && (cl != LEN_9);
  assign last    = nd + (has_par ? 1 : 0);
  assign exp_par = (pm == PAR_EVEN) ? acc : ~acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= rxd;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_WAIT_HI;
      cnt  <= '0;
      bi   <= '0;
      acc  <= 1'b0;
      pb   <= 1'b0;
      data <= '0;
      done <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st  <= ST_WAIT_HI;
        cnt <= '0;
      end else begin
        case (st)
          ST_WAIT_HI: begin
            cnt <= '0;
            if (s2) st <= ST_IDLE;
          end
          ST_IDLE: begin
            if (tick) begin
              if (s2) begin
                cnt <= '0;
              end else if (cnt == START_MID) begin
                st   <= ST_RUN;
                cnt  <= '0;
                bi   <= '0;
                acc  <= 1'b0;
                data <= '0;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
          default: begin
            if (tick) begin
              if (cnt == SUB_LAST) begin
                cnt <= '0;
                if (int'(bi) < nd) begin
                  data[bi] <= s2;
                  acc      <= acc ^ s2;
                end else if (has_par && (int'(bi) == nd)) begin
                  pb <= s2;
                end
                if (int'(bi) == last) begin
                  done <= 1'b1;
                  ferr <= !s2;
                  perr <= chk_par && (pb != exp_par);
                  st   <= ST_WAIT_HI;
                end else begin
                  bi <= bi + 1'b1;
                end
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/aser_rx_buffer.sv
module aser_rx_buffer
  import aser_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                done,
  input  logic [MAX_DATA-1:0] in_data,
  input  logic                perr,
  input  logic                ferr,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [MAX_DATA-1:0] out_data,
  output logic                end_pulse,
  output logic                err_pulse,
  input  logic                stat_rd,
  output logic [2:0]          flags
);
  logic full_blocked;
  logic load;
  logic ovr;
  logic [2:0] new_err;

  assign full_blocked = out_valid && !out_ready;
  assign load    = done && en && !full_blocked;
  assign ovr     = done && en && full_blocked;
  assign new_err = {ovr, done && en && ferr, done && en && perr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      end_pulse <= 1'b0;
      err_pulse <= 1'b0;
      flags     <= '0;
    end else begin
      out_valid <= load || full_blocked;
      if (load) out_data <= in_data;
      end_pulse <= load;
      err_pulse <= |new_err;
      flags     <= (stat_rd ? 3'b000 : flags) | new_err;
    end
  end
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import aser_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_clk_sel,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic [1:0]          cfg_len,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_stop2,
  input  logic                tx_en,
  input  logic                rx_en,
  input  logic                tx_valid,
  output logic                tx_ready,
  input  logic [MAX_DATA-1:0] tx_data,
  output logic                txd,
  input  logic                rxd,
  output logic                rx_valid,
  input  logic                rx_ready,
  output logic [MAX_DATA-1:0] rx_data,
  output logic                tx_end,
  output logic                rx_end,
  output logic                err_irq,
  input  logic                stat_rd,
  output logic [2:0]          stat_flags
);
  logic                tick;
  logic                rx_done;
  logic [MAX_DATA-1:0] rx_word;
  logic                rx_perr;
  logic                rx_ferr;

  aser_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (cfg_clk_sel),
    .div  (cfg_div),
    .tick (tick)
  );

  aser_tx_engine u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .len     (cfg_len),
    .par     (cfg_par),
    .stop2   (cfg_stop2),
    .en      (tx_en),
    .in_valid(tx_valid),
    .in_ready(tx_ready),
    .in_data (tx_data),
    .txd     (txd),
    .done    (tx_end)
  );

  aser_rx_engine u_rx (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .en   (rx_en),
    .len  (cfg_len),
    .par  (cfg_par),
    .rxd  (rxd),
    .done (rx_done),
    .data (rx_word),
    .perr (rx_perr),
    .ferr (rx_ferr)
  );

  aser_rx_buffer u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .done     (rx_done),
    .in_data  (rx_word),
    .perr     (rx_perr),
    .ferr     (rx_ferr),
    .out_valid(rx_valid),
    .out_ready(rx_ready),
    .out_data (rx_data),
    .end_pulse(rx_end),
    .err_pulse(err_irq),
    .stat_rd  (stat_rd),
    .flags    (stat_flags)
  );
endmodule

// File: rtl/aser_checker.sv
module aser_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [8:0] rx_data,
  input logic       tx_end,
  input logic       rx_end,
  input logic       err_irq,
  input logic       stat_rd,
  input logic [2:0] stat_flags
);
  a_r5_ready_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);
  a_r5_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);
  a_r6_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |=> !tx_end);
  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));
  a_r8_end_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_end |-> rx_valid);
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_end);
  a_r13_err_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> (stat_flags != 3'b000));
  a_r13_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((stat_flags == 3'b000) || err_irq));
endmodule

bind async_serial_port aser_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_en     (rx_en),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .txd       (txd),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .tx_end    (tx_end),
  .rx_end    (rx_end),
  .err_irq   (err_irq),
  .stat_rd   (stat_rd),
  .stat_flags(stat_flags)
);

// File: tb/async_serial_port_tb.sv
`timescale 1ns/1ps
module async_serial_port_tb;
  typedef bit bq_t[$];

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_clk_sel = 1'b0;
  logic [7:0] cfg_div = 8'd3;
  logic [1:0] cfg_len = 2'd1;
  logic [1:0] cfg_par = 2'd0;
  logic       cfg_stop2 = 1'b0;
  logic       tx_en = 1'b1;
  logic       rx_en = 1'b1;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [8:0] tx_data = '0;
  logic       txd;
  logic       rxd = 1'b1;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [8:0] rx_data;
  logic       tx_end, rx_end, err_irq;
  logic       stat_rd = 1'b0;
  logic [2:0] stat_flags;

  int n_chk = 0;
  int n_fail = 0;
  int n_txend = 0, n_rxend = 0, n_err = 0;
  int P = 4;
  bit finished = 0;

  always #10 clk = ~clk;

  async_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_clk_sel(cfg_clk_sel), .cfg_div(cfg_div),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
    .tx_en(tx_en), .rx_en(rx_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .txd(txd), .rxd(rxd), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .tx_end(tx_end), .rx_end(rx_end),
    .err_irq(err_irq), .stat_rd(stat_rd), .stat_flags(stat_flags)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_end)  n_txend++;
      if (rx_end)  n_rxend++;
      if (err_irq) n_err++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bq_t mk_frame(input int data, input int len, input int par,
                                   input bit stop2, input bit bad_par, input bit bad_stop);
    bq_t q;
    int nd = (len == 0) ? 7 : (len == 2) ? 9 : 8;
    int ones = 0;
    bit pb;
    q.push_back(1'b0);
    for (int i = 0; i < nd; i++) begin
      q.push_back(data[i]);
      ones += data[i];
    end
    if (par != 0 && nd != 9) begin
      if (par == 1)      pb = 1'b0;
      else if (par == 3) pb = (ones % 2) == 1;
      else               pb = (ones % 2) == 0;
      q.push_back(pb ^ bad_par);
    end
    q.push_back(!bad_stop);
    if (stop2) q.push_back(1'b1);
    return q;
  endfunction

  task automatic set_cfg(input bit sel, input int len, input int par, input bit stop2);
    @(negedge clk);
    cfg_clk_sel = sel;
    cfg_len     = 2'(len);
    cfg_par     = 2'(par);
    cfg_stop2   = stop2;
    P = sel ? 2 : int'(cfg_div) + 1;
  endtask

  task automatic tx_frame(input string req, input int data);
    bq_t q = mk_frame(data, int'(cfg_len), int'(cfg_par), cfg_stop2, 0, 0);
    int B = 16 * P;
    int el = 0;
    int e0;
    while (!tx_ready) @(negedge clk);
    tx_data  = 9'(data);
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    e0 = n_txend;
    chk("R5", "tx_ready low while busy", int'(tx_ready), 0);
    for (int k = 0; k < q.size(); k++) begin
      int tgt = k * B + 8 * P;
      repeat (tgt - el) @(negedge clk);
      el = tgt;
      chk(req, $sformatf("txd bit %0d of %0h", k, data), int'(txd), int'(q[k]));
    end
    chk("R6", "no tx_end before last bit", n_txend, e0);
    repeat (B) @(negedge clk);
    chk("R6", "one tx_end per frame", n_txend, e0 + 1);
    chk("R5", "tx_ready back after frame", int'(tx_ready), 1);
  endtask

  task automatic rx_drive(input bq_t q);
    int B = 16 * P;
    for (int k = 0; k < q.size(); k++) begin
      rxd = q[k];
      repeat (B) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (B / 2) @(negedge clk);
  endtask

  task automatic rd_status();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk("R13", "flags cleared by read", int'(stat_flags), 0);
  endtask

  task automatic take();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk("R8", "buffer empty after take", int'(rx_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int r0, e0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "txd idle", int'(txd), 1);
    chk("R1", "rx_valid", int'(rx_valid), 0);
    chk("R1", "flags", int'(stat_flags), 0);
    chk("R1", "tx_ready", int'(tx_ready), 1);

    // transmit patterns
    set_cfg(0, 1, 0, 0); tx_frame("R3", 'hA5);
    set_cfg(0, 0, 3, 1); tx_frame("R4", 'h53);
    set_cfg(0, 1, 2, 0); tx_frame("R4", 'h0F);
    set_cfg(0, 2, 3, 0); tx_frame("R3", 'h1C3);
    set_cfg(0, 1, 1, 0); tx_frame("R4", 'hFF);
    set_cfg(1, 1, 0, 1); tx_frame("R2", 'h3C);
    set_cfg(0, 1, 0, 0);

    // R5: disabled transmitter ignores a held request
    begin
      int lowseen = 0;
      tx_en = 1'b0;
      tx_data = 9'h000;
      tx_valid = 1'b1;
      repeat (3 * 16 * P) begin
        @(negedge clk);
        if (txd !== 1'b1) lowseen++;
      end
      chk("R5", "txd quiet while disabled", lowseen, 0);
      chk("R5", "tx_ready low while disabled", int'(tx_ready), 0);
      tx_valid = 1'b0;
      @(negedge clk);
      tx_en = 1'b1;
    end

    // receive patterns
    r0 = n_rxend; e0 = n_err;
    rx_drive(mk_frame('h96, 1, 0, 0, 0, 0));
    chk("R8", "rx_valid", int'(rx_valid), 1);
    chk("R8", "rx_data", int'(rx_data), 'h96);
    chk("R8", "one rx_end", n_rxend, r0 + 1);
    chk("R8", "no flags", int'(stat_flags), 0);

    r0 = n_rxend;
    rx_drive(mk_frame('h33, 1, 0, 0, 0, 0));
    chk("R12", "overrun flag", int'(stat_flags), 3'b100);
    chk("R12", "old data kept", int'(rx_data), 'h96);
    chk("R12", "no rx_end on overrun", n_rxend, r0);
    chk("R13", "one err pulse", n_err, e0 + 1);
    rd_status();
    take();

    set_cfg(0, 2, 3, 0);
    rx_drive(mk_frame('h155, 2, 3, 0, 0, 0));
    chk("R4", "9-bit data, no parity bit", int'(rx_data), 'h155);
    chk("R4", "9-bit flags", int'(stat_flags), 0);
    take();

    set_cfg(0, 0, 3, 0);
    e0 = n_err;
    rx_drive(mk_frame('h2A, 0, 3, 0, 1, 0));
    chk("R10", "parity flag", int'(stat_flags), 3'b001);
    chk("R10", "data still loaded", int'(rx_data), 'h2A);
    chk("R13", "err pulse on parity", n_err, e0 + 1);
    rd_status();
    take();
    rx_drive(mk_frame('h2B, 0, 3, 0, 0, 0));
    chk("R10", "even parity good", int'(stat_flags), 0);
    chk("R10", "7-bit data", int'(rx_data), 'h2B);
    take();

    set_cfg(0, 1, 2, 0);
    rx_drive(mk_frame('h0F, 1, 2, 0, 0, 0));
    chk("R10", "odd parity good", int'(stat_flags), 0);
    take();

    set_cfg(0, 1, 1, 0);
    rx_drive(mk_frame('hC4, 1, 1, 0, 1, 0));
    chk("R10", "zero parity not checked", int'(stat_flags), 0);
    chk("R8", "zero parity data", int'(rx_data), 'hC4);
    take();

    set_cfg(0, 1, 0, 0);
    rx_drive(mk_frame('h5A, 1, 0, 0, 0, 1));
    chk("R11", "framing flag", int'(stat_flags), 3'b010);
    chk("R11", "data still loaded", int'(rx_data), 'h5A);
    rd_status();
    take();

    r0 = n_rxend;
    @(negedge clk); rx_en = 1'b0;
    rx_drive(mk_frame('h11, 1, 0, 0, 0, 0));
    chk("R9", "nothing loaded", int'(rx_valid), 0);
    chk("R9", "no rx_end", n_rxend, r0);
    rx_en = 1'b1;
    repeat (16 * P) @(negedge clk);

    r0 = n_rxend;
    rxd = 1'b0;
    repeat (5 * P) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * 16 * P * 12) @(negedge clk);
    chk("R7", "glitch ignored", int'(rx_valid), 0);
    chk("R7", "no rx_end on glitch", n_rxend, r0);
    rx_drive(mk_frame('h7E, 1, 0, 0, 0, 0));
    chk("R7", "frame after glitch", int'(rx_data), 'h7E);
    take();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule